// File: doc/BRIEF.md
# Passive Tag Identity Serializer and Modulator

This block is the digital transmit path of a read-only passive identification tag. It runs on the clock recovered from the reader's 13.56 MHz carrier. A single free-running counter derives every timing signal: a subcarrier at one sixteenth of the carrier, a half-bit clock for Manchester coding, and a bit index. The bit index picks one bit at a time out of a 128-bit identity code that is fixed when the block is built.

Each selected bit is Manchester coded by an XOR with the half-bit clock. The coded stream then gates the subcarrier with an AND to form a single modulation-enable line, which drives an external load-modulation switch. When the coded value is low the subcarrier is fully blocked, so the modulation index is 100%.

The code is sent continuously, most significant bit first, and wraps around for as long as power is present. There are no commands and no state machine. The only input besides the clock is a power-on reset.

Top module: `tagser_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, `mod_en` is low after that edge. A reset also returns the counter to zero, so transmission restarts at the first bit.
- R2: Each bit occupies exactly 128 carrier cycles and is split into two halves of 64 cycles. After reset is released, slot s covers counter values s*128 to s*128+127.
- R3: Manchester rule. A bit of value 1 puts subcarrier activity in the first half of its slot and none in the second half. A bit of value 0 does the reverse. The active half carries exactly 32 high cycles of `mod_en`, and the other half carries none.
- R4: Within an active half, `mod_en` follows the carrier divided by 16. It is high while counter bit 3 is 1 (counter values 8 to 15 modulo 16) and low otherwise.
- R5: Slot s carries identity bit `ID_VALUE[127 - s]`, so bit 127 goes out first and bit 0 goes out last.
- R6: After slot 127 the sequence wraps to bit 127 again. The output is periodic with a period of 128*128 = 16384 cycles.
- R7: `mod_en` is registered and reflects the counter value from two edges earlier. Counting edge 1 as the first edge after reset is released, `mod_en` after edge n equals the R3/R4 value for counter value n-2. When `ID_VALUE[127]` is 1, the first high appears after edge 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock, 13.56 MHz |
| rst | input | 1 | Synchronous active-high power-on reset |
| mod_en | output | 1 | Registered modulation enable for the load switch |

## Verification
The bench uses an identity pattern that mixes alternating nibbles, all-zero and all-one words, single set bits and an irregular tail. Decoding then separates a correct bit order from a reversed or shifted one, and a stuck data path from a working one. Each decoded slot is checked for which half holds the energy and for exactly 32 high cycles, which exposes a swapped Manchester phase or a wrong subcarrier divider. The whole captured waveform is compared cycle by cycle against an independent model, covering two full periods, so latency errors and wraparound errors stand out. A reset in the middle of a run confirms that the output goes silent and that transmission restarts at the first bit.

// File: rtl/tagser_pkg.sv
package tagser_pkg;
  // default geometry of the transmit path
  localparam int unsigned DEF_ID_BITS   = 128;
  localparam int unsigned DEF_BIT_LOG2  = 7;   // carrier cycles per bit = 2**7
  localparam int unsigned DEF_SUBC_LOG2 = 4;   // subcarrier = carrier / 2**4

  // timing taps taken from the counter
  typedef struct packed {
    logic half;   // 0 in first half of a bit, 1 in second
    logic subc;   // subcarrier square wave
  } taps_t;
endpackage

// File: rtl/tagser_timebase.sv
module tagser_timebase
  import tagser_pkg::*;
#(
  parameter int unsigned BIT_LOG2  = DEF_BIT_LOG2,
  parameter int unsigned SUBC_LOG2 = DEF_SUBC_LOG2,
  parameter int unsigned IDX_W     = 7,
  localparam int unsigned CW       = BIT_LOG2 + IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CW-1:0]    cnt_o,
  output logic [IDX_W-1:0] slot_o,
  output taps_t            taps_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o       = cnt_q;
  assign slot_o      = cnt_q[CW-1:BIT_LOG2];
  assign taps_o.half = cnt_q[BIT_LOG2-1];
  assign taps_o.subc = cnt_q[SUBC_LOG2-1];
endmodule

// File: rtl/tagser_idrom.sv
module tagser_idrom #(
  parameter int unsigned  ID_BITS  = 128,
  parameter logic [ID_BITS-1:0] ID_VALUE = '0,
  localparam int unsigned IDX_W    = $clog2(ID_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] slot_i,
  output logic [IDX_W-1:0] addr_o,
  output logic             bit_q
);
  // one-bit-wide read-only array, filled from the parameter
  logic rom [ID_BITS];

  for (genvar i = 0; i < ID_BITS; i++) begin : g_fill
    assign rom[i] = ID_VALUE[i];
  end

  // most significant bit first: address counts down as the slot counts up
  // (ID_BITS is a power of two, so ID_BITS-1-slot equals ~slot)
  assign addr_o = ~slot_i;

  always_ff @(posedge clk) begin
    if (rst) bit_q <= 1'b0;
    else     bit_q <= rom[addr_o];
  end
endmodule

// File: rtl/tagser_coder.sv
module tagser_coder
  import tagser_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  data_q_i,  // already registered by the ROM stage
  input  taps_t taps_i,
  output taps_t taps_q,
  output logic  mod_en_q
);
  logic coded;

  // align timing taps with the registered data bit
  always_ff @(posedge clk) begin
    if (rst) taps_q <= '0;
    else     taps_q <= taps_i;
  end

  // Manchester: data XOR half-bit clock; then gate subcarrier
  assign coded = data_q_i ^ taps_q.half;

  always_ff @(posedge clk) begin
    if (rst) mod_en_q <= 1'b0;
    else     mod_en_q <= coded & taps_q.subc;
  end
endmodule

// File: rtl/tagser_top.sv
module tagser_top
  import tagser_pkg::*;
#(
  parameter int unsigned ID_BITS   = DEF_ID_BITS,
  parameter int unsigned BIT_LOG2  = DEF_BIT_LOG2,
  parameter int unsigned SUBC_LOG2 = DEF_SUBC_LOG2,
  parameter logic [ID_BITS-1:0] ID_VALUE = 128'hA5C3_0000_FFFF_1234_8000_0001_DEAD_BEEF,
  localparam int unsigned IDX_W    = $clog2(ID_BITS),
  localparam int unsigned CW       = BIT_LOG2 + IDX_W
) (
  input  logic clk,
  input  logic rst,
  output logic mod_en
);
  logic [CW-1:0]    cnt_w;
  logic [IDX_W-1:0] slot_w;
  logic [IDX_W-1:0] addr_w;
  logic             data_q_w;
  taps_t            taps_w;
  taps_t            taps_q_w;

  tagser_timebase #(
    .BIT_LOG2  (BIT_LOG2),
    .SUBC_LOG2 (SUBC_LOG2),
    .IDX_W     (IDX_W)
  ) timebase_i (
    .clk    (clk),
    .rst    (rst),
    .cnt_o  (cnt_w),
    .slot_o (slot_w),
    .taps_o (taps_w)
  );

  tagser_idrom #(
    .ID_BITS  (ID_BITS),
    .ID_VALUE (ID_VALUE)
  ) idrom_i (
    .clk    (clk),
    .rst    (rst),
    .slot_i (slot_w),
    .addr_o (addr_w),
    .bit_q  (data_q_w)
  );

  tagser_coder coder_i (
    .clk      (clk),
    .rst      (rst),
    .data_q_i (data_q_w),
    .taps_i   (taps_w),
    .taps_q   (taps_q_w),
    .mod_en_q (mod_en)
  );
endmodule

// File: rtl/tagser_chk.sv
module tagser_chk
  import tagser_pkg::*;
#(
  parameter int unsigned CW       = 14,
  parameter int unsigned BIT_LOG2 = 7,
  parameter int unsigned IDX_W    = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             mod_en,
  input logic [CW-1:0]    cnt_w,
  input logic [IDX_W-1:0] addr_w,
  input logic             data_q_w,
  input taps_t            taps_q_w
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk) rst |=> !mod_en);

  // R4
  subc_gate_chk: assert property (@(posedge clk) disable iff (rst)
    mod_en |-> $past(taps_q_w.subc));

  // R3
  manch_chk: assert property (@(posedge clk) disable iff (rst)
    mod_en |-> ($past(data_q_w) != $past(taps_q_w.half)));

  // R2
  bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(data_q_w) |-> ($past(cnt_w[BIT_LOG2-1:0]) == '0));

  // R5 R6
  order_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_w[BIT_LOG2-1:0] == '1) |=> (addr_w == $past(addr_w) - 1'b1));
endmodule

bind tagser_top tagser_chk #(
  .CW       (CW),
  .BIT_LOG2 (BIT_LOG2),
  .IDX_W    (IDX_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .mod_en   (mod_en),
  .cnt_w    (cnt_w),
  .addr_w   (addr_w),
  .data_q_w (data_q_w),
  .taps_q_w (taps_q_w)
);

// File: tb/tagser_top_tb_top.sv
module tagser_top_tb_top;
  localparam logic [127:0] PAT = 128'hA5C3_0000_FFFF_1234_8000_0001_DEAD_BEEF;
  localparam int PERIOD = 16384;
  localparam int SPAN   = 2*PERIOD + 16;

  // {slot, expected bit}
  localparam logic [7:0] VEC [12] = '{
    {7'd0, 1'b1},  {7'd1, 1'b0},  {7'd2, 1'b1},  {7'd5, 1'b1},
    {7'd20, 1'b0}, {7'd40, 1'b1}, {7'd64, 1'b1}, {7'd65, 1'b0},
    {7'd94, 1'b0}, {7'd95, 1'b1}, {7'd120, 1'b1}, {7'd123, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mod_en;
  logic samp [0:SPAN];
  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  tagser_top #(.ID_VALUE(PAT)) dut_i (.clk(clk), .rst(rst), .mod_en(mod_en));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected output after edge n (n >= 2), counter value n-2
  function automatic logic model(input int n);
    int v = n - 2;
    int slot = (v / 128) % 128;
    logic b = PAT[127 - slot];
    logic h = v[6];
    logic s = v[3];
    return (b ^ h) & s;
  endfunction

  function automatic int ones(input int slot, input int half);
    int c = 0;
    int base = slot*128 + half*64 + 2;
    for (int k = 0; k < 64; k++) c += int'(samp[base + k]);
    return c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int mism;
    int c0;
    int c1;
    // R1: output low while reset held
    repeat (4) @(posedge clk);
    #1 check(mod_en == 1'b0, "R1 reset", int'(mod_en), 0);
    @(negedge clk) rst = 1'b0;
    samp[0] = mod_en;
    for (int n = 1; n <= SPAN; n++) begin
      @(posedge clk); #1 samp[n] = mod_en;
    end

    // R7 latency and R4 subcarrier phase at the start
    check(samp[9] == 1'b0,  "R7 edge9",  int'(samp[9]), 0);
    check(samp[10] == 1'b1, "R7 edge10", int'(samp[10]), 1);
    check(samp[17] == 1'b1, "R4 edge17", int'(samp[17]), 1);
    check(samp[18] == 1'b0, "R4 edge18", int'(samp[18]), 0);

    // R4 R7 full waveform against model
    mism = 0;
    for (int n = 2; n <= SPAN; n++) if (samp[n] !== model(n)) mism++;
    check(mism == 0, "R4 R7 waveform mismatches", mism, 0);

    // R3 R5: decode table slots
    for (int i = 0; i < 12; i++) begin
      int sl = int'(VEC[i][7:1]);
      logic eb = VEC[i][0];
      c0 = ones(sl, 0);
      c1 = ones(sl, 1);
      check((c0 > c1) == eb, "R5 decoded bit", int'(c0 > c1), int'(eb));
      check(eb ? (c0 == 32 && c1 == 0) : (c0 == 0 && c1 == 32),
            "R3 half energy", c0*100 + c1, eb ? 3200 : 32);
    end

    // R2: slot 1 (bit 0) activity begins at counter 200 -> edge 202
    check(samp[201] == 1'b0, "R2 slot1 edge201", int'(samp[201]), 0);
    check(samp[202] == 1'b1, "R2 slot1 edge202", int'(samp[202]), 1);

    // R6: wraparound
    mism = 0;
    for (int n = 2; n + PERIOD <= SPAN; n++) if (samp[n] !== samp[n + PERIOD]) mism++;
    check(mism == 0, "R6 period mismatches", mism, 0);
    c0 = ones(128, 0);
    c1 = ones(128, 1);
    check(c0 == 32 && c1 == 0, "R6 slot128 equals bit127", c0, 32);

    // R1: reset mid-run silences output and restarts at bit 127
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1 check(mod_en == 1'b0, "R1 midrun reset", int'(mod_en), 0);
    repeat (2) @(posedge clk);
    #1 check(mod_en == 1'b0, "R1 reset held", int'(mod_en), 0);
    @(negedge clk) rst = 1'b0;
    for (int n = 1; n <= 20; n++) begin
      @(posedge clk); #1 samp[n] = mod_en;
    end
    check(samp[9] == 1'b0,  "R1 restart edge9",  int'(samp[9]), 0);
    check(samp[10] == 1'b1, "R1 restart edge10", int'(samp[10]), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule